// File: doc/BRIEF.md
# Read-Disturb Tracking Table

This block watches the read and write commands that a media controller sends to one bank of phase-change memory. It keeps a few entries, each naming a word address that is at risk of read-induced bit flips. For every tracked word it keeps a read count and the number of zero bits last written to it. A read can only flip a cell that holds a zero. Reads therefore add to the count only while the word is known to hold zeros. A read carries no data, so zero information is learned late, from writes that hit the same address.

When a tracked word has been read often enough, the block asks for the word to be rewritten, which restores the weakened cells. Misses are inserted at random, so that one-off accesses do not churn the table. When the table is full, the least urgent entry is replaced, and a small random share of replaced addresses is also sent for a rewrite. Each bank gets its own instance. The request output can be stalled, and the command input then stalls with it.

Top module: `rd_disturb_tracker`

## Requirements
- R1: While reset is asserted and just after it, no entry is valid, `req_valid_o` is 0 and `cmd_ready_o` is 1.
- R2: Random decisions come from a 16-bit register. It is loaded with 16'hACE1 in reset and shifts left on every clock, taking in bit15^bit13^bit12^bit10 at bit 0. A command is judged with the value the register holds in the cycle before the edge that updates the table.
- R3: A command accepted at clock edge n updates the table at edge n+1, and any request it causes shows on `req_valid_o` after edge n+1.
- R4: On a write hit, the entry's zero count becomes the number of 0 bits in `cmd_data_i`. The read count goes up by one only when that new zero count is 0.
- R5: On a read hit, the read count goes up by one only when the stored zero count is non-zero.
- R6: When an increment brings a read count to THRESH, a request for that address is issued and the read count returns to 0.
- R7: On a miss, an entry is allocated only when random bit 0 is 1. A read miss starts with zero count 0, and a write miss starts with the zero count of its data. Both start with read count 0. The lowest-index invalid entry is filled first.
- R8: With every entry valid, the entry replaced is the one with the smallest read count. Ties go to the smaller zero count, then to the lower index.
- R9: A replacement issues a request for the evicted address only when random bits [4:1] are all 0.
- R10: While `req_valid_o` is 1 and `req_ready_i` is 0, the request address holds, the table does not update and `cmd_ready_o` is 0 if a command is waiting in the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command accepted this cycle when high |
| cmd_wr_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | ADDR_W | Row/column word address |
| cmd_data_i | input | DATA_W | Write data (ignored for reads) |
| req_valid_o | output | 1 | Rewrite request present |
| req_ready_i | input | 1 | Downstream accepts the request |
| req_addr_o | output | ADDR_W | Address to rewrite |

## Verification
The assertions assume that commands arrive as a valid/ready stream: data and address are taken only on a cycle where both are high. They also assume that the downstream side will eventually raise `req_ready_i`, since hold-and-stall properties say nothing about a request that is never taken. The stimulus draws addresses from a small pool, so hits, table-full evictions and tie cases all happen often. It makes some writes all-ones data so that zero counts of 0 occur. It stalls the request side at random, and it never changes a command while that command waits for acceptance.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
  typedef enum logic {CMD_RD = 1'b0, CMD_WR = 1'b1} cmd_e;
  localparam int unsigned LFSR_W = 16;
endpackage

// File: rtl/rdt_lfsr.sv
module rdt_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [15:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= SEED;
    else         q_o <= {q_o[14:0], q_o[15] ^ q_o[13] ^ q_o[12] ^ q_o[10]};
  end
endmodule

// File: rtl/rdt_zero_count.sv
module rdt_zero_count #(
  parameter int unsigned DATA_W = 512,
  localparam int unsigned ZC_W  = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [ZC_W-1:0]   zeros_o
);
  always_comb begin
    zeros_o = '0;
    for (int i = 0; i < DATA_W; i++) zeros_o = zeros_o + ZC_W'(~data_i[i]);
  end
endmodule

// File: rtl/rdt_victim.sv
module rdt_victim #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned RC_W    = 11,
  parameter int unsigned ZC_W    = 10,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES*RC_W-1:0] rc_i,
  input  logic [ENTRIES*ZC_W-1:0] zc_i,
  output logic [IDX_W-1:0]        idx_o
);
  logic [RC_W-1:0] best_rc;
  logic [ZC_W-1:0] best_zc;
  always_comb begin
    idx_o   = '0;
    best_rc = rc_i[RC_W-1:0];
    best_zc = zc_i[ZC_W-1:0];
    for (int i = 1; i < ENTRIES; i++) begin
      if (rc_i[i*RC_W +: RC_W] < best_rc ||
          (rc_i[i*RC_W +: RC_W] == best_rc && zc_i[i*ZC_W +: ZC_W] < best_zc)) begin
        idx_o   = IDX_W'(i);
        best_rc = rc_i[i*RC_W +: RC_W];
        best_zc = zc_i[i*ZC_W +: ZC_W];
      end
    end
  end
endmodule

// File: rtl/rd_disturb_tracker.sv
module rd_disturb_tracker
  import rdt_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned ADDR_W  = 25,
  parameter int unsigned DATA_W  = 512,
  parameter int unsigned THRESH  = 1024,
  parameter logic [15:0] SEED    = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_wr_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned RC_W  = $clog2(THRESH + 1);
  localparam int unsigned ZC_W  = $clog2(DATA_W + 1);

  logic [LFSR_W-1:0] rnd;
  logic [ZC_W-1:0]   in_zc;

  rdt_lfsr #(.SEED(SEED)) u_lfsr (.clk_i(clk_i), .rst_ni(rst_ni), .q_o(rnd));
  rdt_zero_count #(.DATA_W(DATA_W)) u_zc (.data_i(cmd_data_i), .zeros_o(in_zc));

  // stage register
  logic              s_vld;
  cmd_e              s_cmd;
  logic [ADDR_W-1:0] s_addr;
  logic [ZC_W-1:0]   s_zc;

  // table
  logic              t_vld  [ENTRIES];
  logic [ADDR_W-1:0] t_addr [ENTRIES];
  logic [RC_W-1:0]   t_rc   [ENTRIES];
  logic [ZC_W-1:0]   t_zc   [ENTRIES];

  logic [ENTRIES*RC_W-1:0] rc_flat;
  logic [ENTRIES*ZC_W-1:0] zc_flat;
  logic [ENTRIES-1:0]      hit;
  logic [IDX_W-1:0]        vic_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
    assign rc_flat[g*RC_W +: RC_W] = t_rc[g];
    assign zc_flat[g*ZC_W +: ZC_W] = t_zc[g];
    assign hit[g] = t_vld[g] && (t_addr[g] == s_addr);
  end

  rdt_victim #(.ENTRIES(ENTRIES), .RC_W(RC_W), .ZC_W(ZC_W)) u_vic (
    .rc_i(rc_flat), .zc_i(zc_flat), .idx_o(vic_idx));

  logic stall, adv;
  assign stall       = req_valid_o && !req_ready_i;
  assign adv         = s_vld && !stall;
  assign cmd_ready_o = !s_vld || !stall;

  logic              hit_any, free_any;
  logic [IDX_W-1:0]  hit_idx, free_idx;
  logic              upd_en, gen;
  logic [IDX_W-1:0]  upd_idx;
  logic [RC_W-1:0]   upd_rc, nrc;
  logic [ZC_W-1:0]   upd_zc;
  logic [ADDR_W-1:0] gen_addr;
  logic              inc;

  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i])    begin hit_any  = 1'b1; hit_idx  = IDX_W'(i); end
      if (!t_vld[i]) begin free_any = 1'b1; free_idx = IDX_W'(i); end
    end
  end

  always_comb begin
    upd_en   = 1'b0;
    upd_idx  = hit_idx;
    upd_rc   = '0;
    upd_zc   = '0;
    gen      = 1'b0;
    gen_addr = s_addr;
    inc      = 1'b0;
    nrc      = '0;
    if (hit_any) begin
      upd_en = 1'b1;
      upd_zc = (s_cmd == CMD_WR) ? s_zc : t_zc[hit_idx];
      inc    = (s_cmd == CMD_WR) ? (s_zc == '0) : (t_zc[hit_idx] != '0);
      nrc    = t_rc[hit_idx] + RC_W'(inc);
      upd_rc = nrc;
      if (nrc == RC_W'(THRESH)) begin
        gen    = 1'b1;
        upd_rc = '0;
      end
    end else if (rnd[0]) begin
      upd_en  = 1'b1;
      upd_idx = free_any ? free_idx : vic_idx;
      upd_zc  = (s_cmd == CMD_WR) ? s_zc : '0;
      if (!free_any && rnd[4:1] == 4'd0) begin
        gen      = 1'b1;
        gen_addr = t_addr[vic_idx];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_vld  <= 1'b0;
      s_cmd  <= CMD_RD;
      s_addr <= '0;
      s_zc   <= '0;
    end else if (cmd_ready_o) begin
      s_vld <= cmd_valid_i;
      if (cmd_valid_i) begin
        s_cmd  <= cmd_e'(cmd_wr_i);
        s_addr <= cmd_addr_i;
        s_zc   <= in_zc;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) begin
        t_vld[i]  <= 1'b0;
        t_addr[i] <= '0;
        t_rc[i]   <= '0;
        t_zc[i]   <= '0;
      end
    end else if (adv && upd_en) begin
      t_vld[upd_idx]  <= 1'b1;
      t_addr[upd_idx] <= s_addr;
      t_rc[upd_idx]   <= upd_rc;
      t_zc[upd_idx]   <= upd_zc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_o <= 1'b0;
      req_addr_o  <= '0;
    end else if (adv && gen) begin
      req_valid_o <= 1'b1;
      req_addr_o  <= gen_addr;
    end else if (req_ready_i) begin
      req_valid_o <= 1'b0;
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));
  // R3
  req_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> $past(s_vld));
  // R7
  hit_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    // R6
    rc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      t_rc[g] < RC_W'(THRESH));
  end
endmodule

// File: tb/sim_rd_disturb_tracker.sv
module sim_rd_disturb_tracker;
  localparam int ENT = 4, AW = 8, DW = 16, TH = 5;
  localparam int NCYC = 6000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_wr = 1'b0, req_ready = 1'b1;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic cmd_ready, req_valid;
  logic [AW-1:0] req_addr;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rd_disturb_tracker #(.ENTRIES(ENT), .ADDR_W(AW), .DATA_W(DW), .THRESH(TH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_wr_i(cmd_wr), .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr));

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d @%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] step(logic [15:0] q);
    return {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
  endfunction

  // reference model state
  bit mv[ENT]; int ma[ENT], mr[ENT], mz[ENT];
  bit sv, swr; int sa, sz;
  bit ov; int oa; string otag = "R3";
  logic [15:0] lf = 16'hACE1;

  initial begin
    foreach (mv[i]) begin mv[i] = 0; ma[i] = 0; mr[i] = 0; mz[i] = 0; end
    sv = 0; swr = 0; sa = 0; sz = 0; ov = 0; oa = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_valid == 1'b0, "R1", "req_valid in reset", req_valid, 0);
    chk(cmd_ready == 1'b1, "R1", "cmd_ready in reset", cmd_ready, 1);
    rst_n = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      bit stall, adv, crdy, gen, ins, hitf, inc, freef;
      int gaddr, hi, fi, vi, nr, r;
      string gtag;
      // drive new inputs unless a command waits for acceptance
      if (!(cmd_valid && !cmd_ready)) begin
        cmd_valid = ($urandom % 4) != 0;
        cmd_wr    = ($urandom % 10) < 3;
        r = $urandom % 10;
        cmd_addr  = AW'((r < 6) ? 1 + (r % 2) : 3 + ($urandom % 4));
        cmd_data  = (($urandom % 5) == 0) ? '1 : DW'($urandom);
      end
      req_ready = ($urandom % 4) != 0;
      #1;
      // compare against model
      chk(req_valid == ov, ov ? otag : "R3", "req_valid", req_valid, ov);
      if (ov && req_valid) chk(req_addr == AW'(oa), otag, "req_addr", req_addr, oa);
      stall = ov && !req_ready;
      adv   = sv && !stall;
      crdy  = !sv || !stall;
      chk(cmd_ready == crdy, "R10", "cmd_ready", cmd_ready, crdy);
      // predict next edge
      gen = 0; gaddr = 0; gtag = "";
      if (adv) begin
        hitf = 0; hi = 0; freef = 0; fi = 0;
        for (int i = ENT - 1; i >= 0; i--) begin
          if (mv[i] && ma[i] == sa) begin hitf = 1; hi = i; end
          if (!mv[i]) begin freef = 1; fi = i; end
        end
        if (hitf) begin
          if (swr) begin mz[hi] = sz; inc = (sz == 0); end  // R4
          else inc = (mz[hi] != 0);                          // R5
          nr = mr[hi] + int'(inc);
          if (nr == TH) begin gen = 1; gaddr = sa; gtag = "R4 R5 R6"; nr = 0; end
          mr[hi] = nr;
        end else begin
          ins = lf[0];                                       // R2 R7
          if (ins) begin
            vi = 0;
            for (int i = 1; i < ENT; i++)                    // R8
              if (mr[i] < mr[vi] || (mr[i] == mr[vi] && mz[i] < mz[vi])) vi = i;
            if (freef) vi = fi;
            else if (lf[4:1] == 4'd0) begin                  // R9
              gen = 1; gaddr = ma[vi]; gtag = "R2 R7 R8 R9";
            end
            mv[vi] = 1; ma[vi] = sa; mr[vi] = 0; mz[vi] = swr ? sz : 0;
          end
        end
      end
      if (adv && gen) begin ov = 1; oa = gaddr; otag = gtag; end
      else if (req_ready) ov = 0;
      if (crdy) begin
        sv = cmd_valid;
        if (cmd_valid) begin
          swr = cmd_wr; sa = int'(cmd_addr); sz = DW - $countones(cmd_data);
        end
      end
      lf = step(lf);
      @(negedge clk);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule